// File: doc/BRIEF.md
# Base-Bound Address Translation Unit

This block stands between a processor core and its memory bus. It replaces a paging TLB with two base-and-bound windows, one for instruction fetches and one for data loads and stores. The core programs four 32-bit translation registers through a coprocessor register write port. Writes to any other register index are passed on unchanged to the core's general coprocessor register file.

Each access request carries a virtual address, a privilege mode, a fetch flag, a store flag and an access size. In kernel mode the address passes through untouched. In supervisor mode the address is only checked for a legal segment. In user mode the address is first checked for a legal segment. Its page-aligned value is then compared with the selected bound, and the selected base is added to it. One cycle after a request the block either issues a memory request with the physical address or raises a one-cycle address-error pulse. The pulse gives the error kind (load or store) and the untranslated faulting address.

The response side is a three-state machine. RSP_IDLE means nothing was requested. RSP_ISSUE means a translated request is on the bus. RSP_FAULT means an address error is being reported. From any state, the next state is RSP_FAULT when a request is present and fails its check, RSP_ISSUE when a request is present and passes, and RSP_IDLE when no request is present.

Top module: `bbx_xlate`

## Requirements
- R1: After reset all four translation registers hold zero, and neither mem_valid nor exc_valid is asserted. A user access in page 0 therefore passes with an unchanged address, and a user access at 0x0000_1000 faults.
- R2: A write with cfg_idx 0, 1, 2 or 3 loads the instruction base, instruction bound, data base or data bound respectively. It is not forwarded (fwd_we stays low). The new value applies to requests presented from the next cycle on, and a request in the same cycle as the write still uses the old value.
- R3: A write with cfg_idx of 4 or above asserts fwd_we in the same cycle, with fwd_idx and fwd_wdata equal to cfg_idx and cfg_wdata. It leaves all four translation registers unchanged.
- R4: In kernel mode (req_mode 2'b00) the physical address equals the virtual address for every address, including those with bit 31 set, and no fault is raised.
- R5: In supervisor mode (req_mode 2'b01) an address with bit 31 clear, or with bits 31:29 equal to 3'b110, passes unchanged. Any other address faults.
- R6: In user mode (req_mode 2'b10, and the code 2'b11 treated the same way) an address with bit 31 set faults whatever the bound.
- R7: In user mode the virtual address with its low 12 bits cleared is compared with the selected bound. It faults only when strictly greater, so an address inside the bound page itself passes.
- R8: A passing user access has physical address = virtual address + selected base, modulo 2^32.
- R9: Fetches (req_ifetch=1) use the instruction base and bound. Loads and stores use the data base and bound.
- R10: A faulting store reports exc_store=1. A faulting load or fetch reports exc_store=0. exc_badaddr carries the untranslated virtual address. A fetch is always a read even when req_store is also set.
- R11: On a fault mem_valid stays low and core_rdata is zero. Otherwise core_rdata follows mem_rdata, and mem_size, mem_store and mem_ifetch carry the request's values.
- R12: Results appear exactly one cycle after the request. exc_valid and mem_valid are never high together, and both are low in a cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coprocessor register write strobe |
| cfg_idx | input | 5 | Coprocessor register index |
| cfg_wdata | input | 32 | Coprocessor write data |
| fwd_we | output | 1 | Write forwarded to the general register file |
| fwd_idx | output | 5 | Forwarded register index |
| fwd_wdata | output | 32 | Forwarded write data |
| req_valid | input | 1 | Access request present |
| req_vaddr | input | 32 | Virtual address |
| req_mode | input | 2 | Privilege: 00 kernel, 01 supervisor, 10/11 user |
| req_ifetch | input | 1 | Instruction fetch |
| req_store | input | 1 | Store (ignored on fetches) |
| req_size | input | 2 | Access size code, passed through |
| mem_valid | output | 1 | Translated memory request |
| mem_paddr | output | 32 | Physical address |
| mem_store | output | 1 | Request is a store |
| mem_ifetch | output | 1 | Request is a fetch |
| mem_size | output | 2 | Access size code |
| mem_rdata | input | 64 | Read data from memory |
| core_rdata | output | 64 | Read data to core, zero on a fault |
| exc_valid | output | 1 | Address-error pulse |
| exc_store | output | 1 | 1 for store error, 0 for load error |
| exc_badaddr | output | 32 | Faulting virtual address |

## Verification
The sweep aims at the bound comparison edge. An address in the bound page itself, one byte below it, the last byte of that page and the first byte of the next page are all tried. A design that compared the raw address, or used greater-or-equal, would fault inside the bound page or pass the page after it. Every value of the top three address bits is tried in every mode, which exposes a design that applies the user segment rule to supervisor mode or checks the wrong bit pattern for the supervisor window. A data base near the top of the address space forces the sum to wrap. Fetch-versus-load pairs at the same address catch swapped register pairs. A register write in the same cycle as a request catches a bypass that applies the new bound one cycle early.

// File: rtl/bbx_pkg.sv
package bbx_pkg;

    typedef enum logic [1:0] {
        PRIV_KERN = 2'b00,
        PRIV_SUPV = 2'b01,
        PRIV_USER = 2'b10,
        PRIV_RSVD = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'b00,
        RSP_ISSUE = 2'b01,
        RSP_FAULT = 2'b10
    } rsp_state_e;

    localparam int unsigned SLOT_IBASE  = 0;
    localparam int unsigned SLOT_IBOUND = 1;
    localparam int unsigned SLOT_DBASE  = 2;
    localparam int unsigned SLOT_DBOUND = 3;
    localparam int unsigned NUM_SLOTS   = 4;

    localparam logic [2:0] SUPV_WINDOW = 3'b110;

endpackage

// File: rtl/bbx_regs.sv
module bbx_regs
    import bbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] ibase,
    output logic [ADDR_W-1:0] ibound,
    output logic [ADDR_W-1:0] dbase,
    output logic [ADDR_W-1:0] dbound,
    output logic              fwd_we,
    output logic [IDX_W-1:0]  fwd_idx,
    output logic [ADDR_W-1:0] fwd_wdata
);

    logic [ADDR_W-1:0] slot_q [NUM_SLOTS];
    logic              local_hit;

    assign local_hit = cfg_idx < IDX_W'(NUM_SLOTS);

    // Writes outside the translation slots go to the general file.
    assign fwd_we    = cfg_we && !local_hit;
    assign fwd_idx   = cfg_idx;
    assign fwd_wdata = cfg_wdata;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (cfg_we && cfg_idx == IDX_W'(g))
                slot_q[g] <= cfg_wdata;
        end

        p_slot_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_idx == IDX_W'(g)) |=> (slot_q[g] == $past(cfg_wdata)));

        p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_idx == IDX_W'(g)) |=> $stable(slot_q[g]));
    end

    assign ibase  = slot_q[SLOT_IBASE];
    assign ibound = slot_q[SLOT_IBOUND];
    assign dbase  = slot_q[SLOT_DBASE];
    assign dbound = slot_q[SLOT_DBOUND];

endmodule

// File: rtl/bbx_check.sv
module bbx_check
    import bbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        mode,
    input  logic              ifetch,
    input  logic [ADDR_W-1:0] ibase,
    input  logic [ADDR_W-1:0] ibound,
    input  logic [ADDR_W-1:0] dbase,
    input  logic [ADDR_W-1:0] dbound,
    output logic              fault,
    output logic [ADDR_W-1:0] paddr
);

    localparam logic [ADDR_W-1:0] OFS_MASK =
        {{(ADDR_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

    priv_e             priv;
    logic [ADDR_W-1:0] sel_base;
    logic [ADDR_W-1:0] sel_bound;
    logic [ADDR_W-1:0] page_addr;
    logic [2:0]        seg;
    logic              high;

    assign priv      = priv_e'(mode);
    assign sel_base  = ifetch ? ibase  : dbase;
    assign sel_bound = ifetch ? ibound : dbound;
    assign page_addr = vaddr & ~OFS_MASK;
    assign seg       = vaddr[ADDR_W-1 -: 3];
    assign high      = vaddr[ADDR_W-1];

    always_comb begin
        fault = 1'b0;
        paddr = vaddr;
        unique case (priv)
            PRIV_KERN: begin
                fault = 1'b0;
                paddr = vaddr;
            end
            PRIV_SUPV: begin
                fault = high && (seg != SUPV_WINDOW);
                paddr = vaddr;
            end
            PRIV_USER, PRIV_RSVD: begin
                if (high)
                    fault = 1'b1;
                else if (page_addr > sel_bound)
                    fault = 1'b1;
                paddr = vaddr + sel_base;
            end
        endcase
    end

endmodule

// File: rtl/bbx_xlate.sv
module bbx_xlate
    import bbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned SIZE_W    = 2,
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              fwd_we,
    output logic [IDX_W-1:0]  fwd_idx,
    output logic [ADDR_W-1:0] fwd_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_mode,
    input  logic              req_ifetch,
    input  logic              req_store,
    input  logic [SIZE_W-1:0] req_size,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_paddr,
    output logic              mem_store,
    output logic              mem_ifetch,
    output logic [SIZE_W-1:0] mem_size,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              exc_valid,
    output logic              exc_store,
    output logic [ADDR_W-1:0] exc_badaddr
);

    logic [ADDR_W-1:0] ibase, ibound, dbase, dbound;
    logic              chk_fault;
    logic [ADDR_W-1:0] chk_paddr;
    logic              eff_store;

    rsp_state_e        rsp_q, rsp_d;
    logic [ADDR_W-1:0] addr_q;
    logic              store_q, ifetch_q;
    logic [SIZE_W-1:0] size_q;

    bbx_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .ibase     (ibase),
        .ibound    (ibound),
        .dbase     (dbase),
        .dbound    (dbound),
        .fwd_we    (fwd_we),
        .fwd_idx   (fwd_idx),
        .fwd_wdata (fwd_wdata)
    );

    bbx_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_check (
        .vaddr  (req_vaddr),
        .mode   (req_mode),
        .ifetch (req_ifetch),
        .ibase  (ibase),
        .ibound (ibound),
        .dbase  (dbase),
        .dbound (dbound),
        .fault  (chk_fault),
        .paddr  (chk_paddr)
    );

    // A fetch is always a read.
    assign eff_store = req_store && !req_ifetch;

    always_comb begin
        if (!req_valid)
            rsp_d = RSP_IDLE;
        else if (chk_fault)
            rsp_d = RSP_FAULT;
        else
            rsp_d = RSP_ISSUE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q    <= RSP_IDLE;
            addr_q   <= '0;
            store_q  <= 1'b0;
            ifetch_q <= 1'b0;
            size_q   <= '0;
        end else begin
            rsp_q <= rsp_d;
            if (req_valid) begin
                addr_q   <= chk_fault ? req_vaddr : chk_paddr;
                store_q  <= eff_store;
                ifetch_q <= req_ifetch;
                size_q   <= req_size;
            end
        end
    end

    always_comb begin
        mem_valid   = 1'b0;
        mem_paddr   = '0;
        mem_store   = 1'b0;
        mem_ifetch  = 1'b0;
        mem_size    = '0;
        exc_valid   = 1'b0;
        exc_store   = 1'b0;
        exc_badaddr = '0;
        core_rdata  = mem_rdata;
        unique case (rsp_q)
            RSP_IDLE: ;
            RSP_ISSUE: begin
                mem_valid  = 1'b1;
                mem_paddr  = addr_q;
                mem_store  = store_q;
                mem_ifetch = ifetch_q;
                mem_size   = size_q;
            end
            RSP_FAULT: begin
                exc_valid   = 1'b1;
                exc_store   = store_q;
                exc_badaddr = addr_q;
                core_rdata  = '0;
            end
            default: ;
        endcase
    end

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_valid && !exc_valid));

    p_kernel_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00) |=> (mem_valid && mem_paddr == $past(req_vaddr)));

    p_supv_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b01 && req_vaddr[ADDR_W-1 -: 3] == SUPV_WINDOW)
        |=> (mem_valid && mem_paddr == $past(req_vaddr)));

    p_user_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode[1] && req_vaddr[ADDR_W-1])
        |=> (exc_valid && exc_badaddr == $past(req_vaddr)));

    p_store_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !req_ifetch) |=> (mem_valid ? mem_store : exc_store));

    p_fetch_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ifetch) |=> (!mem_store && !exc_store));

endmodule

// File: tb/sim_bbx_xlate.sv
module sim_bbx_xlate;

    localparam int CLK_PERIOD = 10;

    logic        clk, rst_n;
    logic        cfg_we;
    logic [4:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic        fwd_we;
    logic [4:0]  fwd_idx;
    logic [31:0] fwd_wdata;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_mode;
    logic        req_ifetch, req_store;
    logic [1:0]  req_size;
    logic        mem_valid;
    logic [31:0] mem_paddr;
    logic        mem_store, mem_ifetch;
    logic [1:0]  mem_size;
    logic [63:0] mem_rdata, core_rdata;
    logic        exc_valid, exc_store;
    logic [31:0] exc_badaddr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] m_ib, m_ibd, m_db, m_dbd;

    bbx_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .fwd_we(fwd_we), .fwd_idx(fwd_idx), .fwd_wdata(fwd_wdata),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_mode(req_mode),
        .req_ifetch(req_ifetch), .req_store(req_store), .req_size(req_size),
        .mem_valid(mem_valid), .mem_paddr(mem_paddr), .mem_store(mem_store),
        .mem_ifetch(mem_ifetch), .mem_size(mem_size),
        .mem_rdata(mem_rdata), .core_rdata(core_rdata),
        .exc_valid(exc_valid), .exc_store(exc_store), .exc_badaddr(exc_badaddr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected outcome computed from the requirements.
    task automatic model(input logic [31:0] va, input logic [1:0] md, input bit f,
                         output bit flt, output logic [31:0] pa, output string tg);
        logic [31:0] bnd, bas;
        bnd = f ? m_ibd : m_dbd;
        bas = f ? m_ib  : m_db;
        flt = 1'b0;
        pa  = va;
        case (md)
            2'b00: tg = "R4";
            2'b01: begin
                tg  = "R5";
                flt = va[31] && (va[31:29] != 3'b110);
            end
            default: begin
                if (va[31]) begin
                    flt = 1'b1; tg = "R6";
                end else if ({va[31:12], 12'h000} > bnd) begin
                    flt = 1'b1; tg = "R7";
                end else begin
                    pa = va + bas; tg = "R8";
                end
            end
        endcase
    endtask

    // Called at a negedge; drives one request and checks it one cycle later.
    task automatic access(input logic [31:0] va, input logic [1:0] md, input bit f,
                          input bit s, input logic [1:0] sz, input string tag_in);
        bit          flt;
        logic [31:0] pa;
        string       tg;
        bit          st;
        model(va, md, f, flt, pa, tg);
        if (tag_in != "") tg = tag_in;
        st = s && !f;
        req_valid  = 1'b1;
        req_vaddr  = va;
        req_mode   = md;
        req_ifetch = f;
        req_store  = s;
        req_size   = sz;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_valid != exc_valid, "R12 exclusive", {mem_valid, exc_valid}, 2'b01);
        if (flt) begin
            chk(exc_valid && !mem_valid, tg, {mem_valid, exc_valid}, 2'b01);
            chk(exc_badaddr == va, "R10 badaddr", exc_badaddr, va);
            chk(exc_store == st, "R10 kind", exc_store, st);
            chk(core_rdata == 64'h0, "R11 zero data", core_rdata, 64'h0);
        end else begin
            chk(mem_valid && !exc_valid, tg, {mem_valid, exc_valid}, 2'b10);
            chk(mem_paddr == pa, tg, mem_paddr, pa);
            chk(mem_store == st && mem_ifetch == f && mem_size == sz, "R11 attrs",
                {mem_store, mem_ifetch, mem_size}, {st, f, sz});
            chk(core_rdata == mem_rdata, "R11 data", core_rdata, mem_rdata);
        end
    endtask

    task automatic cfg_write(input logic [4:0] idx, input logic [31:0] d);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        #1;
        if (idx >= 5'd4)
            chk(fwd_we && fwd_idx == idx && fwd_wdata == d, "R3 forward",
                {fwd_we, fwd_idx, fwd_wdata}, {1'b1, idx, d});
        else
            chk(!fwd_we, "R2 not forwarded", fwd_we, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0;
        case (idx)
            5'd0: m_ib  = d;
            5'd1: m_ibd = d;
            5'd2: m_db  = d;
            5'd3: m_dbd = d;
            default: ;
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_vaddr = '0; req_mode = '0;
        req_ifetch = 1'b0; req_store = 1'b0; req_size = '0;
        mem_rdata = 64'hA5C3_0F1E_7788_9AB4;
        m_ib = '0; m_ibd = '0; m_db = '0; m_dbd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!mem_valid && !exc_valid, "R1 idle after reset", {mem_valid, exc_valid}, 2'b00);
        access(32'h0000_0ABC, 2'b10, 1'b0, 1'b0, 2'd2, "R1");
        access(32'h0000_1000, 2'b10, 1'b1, 1'b0, 2'd2, "R1");
        // R12: quiet cycle after a fault pulse
        @(negedge clk);
        chk(!mem_valid && !exc_valid, "R12 pulse ends", {mem_valid, exc_valid}, 2'b00);

        // R2: program the four registers
        cfg_write(5'd0, 32'h8000_0000);
        cfg_write(5'd1, 32'h0000_5000);
        cfg_write(5'd2, 32'hFFFF_F000);
        cfg_write(5'd3, 32'h0001_2000);

        // R3: forwarded write leaves translation untouched
        cfg_write(5'd7, 32'hDEAD_BEEF);
        cfg_write(5'd31, 32'h0000_0000);
        access(32'h0000_5FFF, 2'b10, 1'b1, 1'b0, 2'd0, "R3 ibound kept");
        access(32'h0000_0010, 2'b10, 1'b0, 1'b0, 2'd0, "R3 dbase kept");

        // R9: same address, fetch faults, load passes via data pair
        access(32'h0001_0000, 2'b10, 1'b1, 1'b0, 2'd3, "R9 fetch");
        access(32'h0001_0000, 2'b10, 1'b0, 1'b0, 2'd3, "R9 load");
        // R8: wrap modulo 2^32
        access(32'h0000_2ABC, 2'b10, 1'b0, 1'b1, 2'd1, "R8 wrap");

        // Sweep: every mode, every access kind, segment and bound-edge addresses
        for (int md = 0; md < 4; md++) begin
            for (int k = 0; k < 4; k++) begin
                for (int a = 0; a < 16; a++) begin
                    logic [31:0] va;
                    logic [31:0] bnd;
                    logic [31:0] ofs;
                    bit f, s;
                    f = (k == 0) || (k == 3);
                    s = (k == 2) || (k == 3);
                    if (a < 8) begin
                        va = {a[2:0], 29'h0ABC_DE1};
                    end else begin
                        bnd = (a < 12) ? m_ibd : m_dbd;
                        case (a % 4)
                            0: ofs = 32'h0000_0000;
                            1: ofs = 32'h0000_0FFF;
                            2: ofs = 32'h0000_1000;
                            default: ofs = 32'hFFFF_FFFF;
                        endcase
                        va = bnd + ofs;
                    end
                    access(va, md[1:0], f, s, a[1:0], "");
                end
            end
        end

        // R2: write takes effect next cycle, same-cycle request uses old bound
        cfg_we = 1'b1; cfg_idx = 5'd1; cfg_wdata = 32'h0000_1000;
        access(32'h0000_3000, 2'b10, 1'b1, 1'b0, 2'd2, "R2 old bound");
        cfg_we = 1'b0;
        m_ibd = 32'h0000_1000;
        access(32'h0000_3000, 2'b10, 1'b1, 1'b0, 2'd2, "R2 new bound");
        access(32'h0000_1FFF, 2'b10, 1'b1, 1'b0, 2'd2, "R7 edge page");

        @(negedge clk);
        chk(!mem_valid && !exc_valid, "R12 idle", {mem_valid, exc_valid}, 2'b00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule